// File: doc/BRIEF.md
# Vector Compute-in-Cache Instruction Sequencer

This block sits between a core and the compute-capable arrays of a cache. It takes one wide vector instruction at a time. Each instruction carries an opcode, up to three base addresses (source A, source B or search key, destination) and a length in 8-byte words. The block first screens the instruction. A bad length, a base that is not aligned to a block, or an operand that runs past a 4 KB page ends the instruction at once with an exception code. A valid instruction is cut into block-sized operations of at most 8 words (one 64-byte block each). Each operation is issued to the array command port only after every operand it uses has been reported resident.

Residency is tracked per operation, one bit per operand. A fetch request goes out for each missing operand. If an external agent takes the lock on a held operand, the residency bits are cleared and the operands are fetched again. A second such loss ends the instruction with a fallback status, and the core then runs it by ordinary means.

Compare and search return one match bit per word, gathered into a 64-bit result. A search first copies its key into each array partition it touches, and only once per partition in each instruction. When the low 12 address bits of the operands disagree, every operation is marked for the near-array logic path.

Top module: `cc_vec_sequencer`

## Requirements
- R1: `insReady` is high only when no instruction is held. An instruction is taken on a clock edge where both `insValid` and `insReady` are high, and `insReady` is low in the cycle after that edge.
- R2: A valid instruction of W words issues ceil(W/8) operation commands. In operation k, `cmdAddrA` is A+64k, `cmdAddrD` is D+64k, and `cmdAddrB` is B+64k, except for search, where it stays B. `cmdWords` is min(8, W-8k), so the values over all operations add up to W.
- R3: An operation command is raised only after a fetch acknowledge has been received for each operand the opcode uses. Operand use by opcode (copy=0, zero=1, and=2, or=3, xor=4, not=5, compare=6, search=7): copy and not use A and D; zero uses D only; and, or and xor use A, B and D; compare and search use A and B. Exactly one acknowledged fetch is made per used operand per operation.
- R4: If any used operand range crosses a 4 KB boundary, the instruction completes with status 1 and exception code 1, and no command is issued. Source and destination ranges are 8·W bytes long; the search key range is 64 bytes.
- R5: A length of 0 words, or more than 64 words for compare or search, completes with status 1 and exception code 2. This check has the highest priority.
- R6: A used base address whose low 6 bits are not zero completes with status 1 and exception code 3. This check ranks below R5 and above R4.
- R7: For compare and search, the match byte `cmdMatch` returned for operation k is stored at result bits [8k+7:8k], with bit j kept only if j < `cmdWords`. All other opcodes return a result of 0.
- R8: Before a search operation whose A block falls in a partition (address bits [7:6]) not yet keyed in this instruction, a key-copy command (`cmdKeyCopy`=1) is issued. There is at most one such copy per partition per instruction.
- R9: `lockLost` during fetching clears residency, and every used operand is fetched again. The second loss within an instruction completes it with status 2, and no further commands are issued.
- R10: `cmdNear` is high on every operation of an instruction when the low 12 address bits of its used operands differ. The search key is left out of this comparison.
- R11: After the last operation is acknowledged, or right after a rejected instruction is taken, `doneValid` pulses for exactly one cycle with status 0 on success.
- R12: After reset, `insReady` is 1 and `fetchValid`, `cmdValid` and `doneValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| insValid | input | 1 | Instruction offered |
| insReady | output | 1 | Instruction can be taken |
| insOp | input | 3 | Opcode |
| insSrcA | input | ADDR_W | Source A base address |
| insSrcB | input | ADDR_W | Source B or search key base address |
| insDst | input | ADDR_W | Destination base address |
| insWords | input | WORDS_W | Length in 8-byte words |
| fetchValid | output | 1 | Operand fetch request |
| fetchSel | output | 2 | Operand fetched: 0=A, 1=B, 2=D |
| fetchAddr | output | ADDR_W | Block address to fetch |
| fetchAck | input | 1 | Requested operand is resident |
| lockLost | input | 1 | Held operand lost to an external request |
| cmdValid | output | 1 | Array command pending |
| cmdKeyCopy | output | 1 | Command is a key copy |
| cmdOp | output | 3 | Opcode of the command |
| cmdNear | output | 1 | Execute on the near-array path |
| cmdWords | output | 4 | Words in this block operation |
| cmdAddrA | output | ADDR_W | Block address A |
| cmdAddrB | output | ADDR_W | Block address B or key |
| cmdAddrD | output | ADDR_W | Block address D |
| cmdAck | input | 1 | Array finished the command |
| cmdMatch | input | 8 | Per-word match bits from the array |
| doneValid | output | 1 | Instruction complete pulse |
| doneStatus | output | 2 | 0 ok, 1 exception, 2 fallback |
| doneExc | output | 2 | Exception code |
| doneResult | output | 64 | Gathered compare/search result |

## Verification
Each instruction is checked on its own, and the bench looks at the command stream, the fetch count and the completion record. The instruction patterns each separate a different fault. Multi-block logical operations with a short last block expose errors in the split and word count. Compare with a partial last block exposes masking and bit placement. A 64-word search that wraps around the partitions shows whether keys are copied exactly once. Offsets with mismatched low bits drive the near-path flag. Lengths and bases chosen to fail one screen, or two screens at once, test the exception priority. One and then two injected lock losses tell a recovered instruction apart from a fallback.

// File: rtl/cc_seq_pkg.sv
package cc_seq_pkg;

  typedef enum logic [2:0] {
    OP_COPY   = 3'd0,
    OP_ZERO   = 3'd1,
    OP_AND    = 3'd2,
    OP_OR     = 3'd3,
    OP_XOR    = 3'd4,
    OP_NOT    = 3'd5,
    OP_CMP    = 3'd6,
    OP_SEARCH = 3'd7
  } ccOp_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_EXC      = 2'd1,
    ST_FALLBACK = 2'd2
  } ccStatus_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_KEY, S_ISSUE, S_DONE
  } seqState_e;

  localparam logic [1:0] EXC_NONE  = 2'd0;
  localparam logic [1:0] EXC_PAGE  = 2'd1;
  localparam logic [1:0] EXC_SIZE  = 2'd2;
  localparam logic [1:0] EXC_ALIGN = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic      latch;
    logic      setPresent;
    logic      bumpRetry;
    logic      setKey;
    logic      accum;
    logic      advance;
    logic      setStatus;
    ccStatus_e status;
  } seqStrobe_t;

  // operand use mask {D, B, A}
  function automatic logic [2:0] opUse(ccOp_e op);
    case (op)
      OP_COPY, OP_NOT:        return 3'b101;
      OP_ZERO:                return 3'b100;
      OP_AND, OP_OR, OP_XOR:  return 3'b111;
      default:                return 3'b011;
    endcase
  endfunction

  function automatic logic isReduce(ccOp_e op);
    return (op == OP_CMP) || (op == OP_SEARCH);
  endfunction

endpackage

// File: rtl/cc_seq_datapath.sv
module cc_seq_datapath
  import cc_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORDS_W     = 8,
  parameter int NUM_PART    = 4,
  parameter int RETRY_LIMIT = 2,
  parameter int RES_W       = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [2:0]         insOp,
  input  logic [ADDR_W-1:0]  insSrcA,
  input  logic [ADDR_W-1:0]  insSrcB,
  input  logic [ADDR_W-1:0]  insDst,
  input  logic [WORDS_W-1:0] insWords,
  input  logic [7:0]         cmdMatch,
  output logic [1:0]         excCode,
  output logic               allPresent,
  output logic               lastOp,
  output logic               needKey,
  output logic               retryLast,
  output logic [1:0]         fetchSel,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic [2:0]         cmdOp,
  output logic               cmdNear,
  output logic [3:0]         cmdWords,
  output logic [ADDR_W-1:0]  cmdAddrA,
  output logic [ADDR_W-1:0]  cmdAddrB,
  output logic [ADDR_W-1:0]  cmdAddrD,
  output logic [1:0]         doneStatus,
  output logic [1:0]         doneExc,
  output logic [RES_W-1:0]   doneResult
);
  localparam int BLK_W     = 6;
  localparam int WPB       = 8;
  localparam int WPB_W     = 3;
  localparam int PAGE_W    = 12;
  localparam int PART_W    = $clog2(NUM_PART);
  localparam int OPS_W     = WORDS_W - WPB_W + 1;
  localparam int CNT_W     = WORDS_W + 1;
  localparam int RETRY_W   = $clog2(RETRY_LIMIT + 1);
  localparam int SUM_W     = PAGE_W + WORDS_W + 4;
  localparam int RES_IDX_W = $clog2(RES_W / WPB);
  localparam int KEY_BYTES = 64;

  function automatic logic pageCross(input logic [PAGE_W-1:0] off,
                                     input logic [SUM_W-1:0] bytes);
    logic [SUM_W-1:0] lastByte;
    lastByte = SUM_W'(off) + bytes - SUM_W'(1);
    return |lastByte[SUM_W-1:PAGE_W];
  endfunction

  // instruction entry
  ccOp_e                curOp;
  logic [ADDR_W-1:0]    baseA, baseB, baseD;
  logic [WORDS_W-1:0]   words;
  logic [OPS_W-1:0]     nextOp;     // next operation to build; equals ops completed
  logic [RES_W-1:0]     result;
  ccStatus_e            status;
  logic [1:0]           excReg;
  logic                 near;
  logic [RETRY_W-1:0]   retryCnt;
  logic [NUM_PART-1:0]  keyTab;
  // operation entry
  logic [2:0]           present;

  // screening of the offered instruction
  ccOp_e      inOp;
  logic [2:0] inUse, locUse;
  logic       sizeBad, alignBad, pageBad, nearIn;
  logic [SUM_W-1:0] insBytes, keyBytes;

  assign inOp     = ccOp_e'(insOp);
  assign inUse    = opUse(inOp);
  assign insBytes = SUM_W'({insWords, 3'b000});
  assign keyBytes = (inOp == OP_SEARCH) ? SUM_W'(KEY_BYTES) : insBytes;
  assign sizeBad  = (insWords == '0) ||
                    (isReduce(inOp) && ({1'b0, insWords} > CNT_W'(RES_W)));
  assign alignBad = (inUse[0] && (insSrcA[BLK_W-1:0] != '0)) ||
                    (inUse[1] && (insSrcB[BLK_W-1:0] != '0)) ||
                    (inUse[2] && (insDst[BLK_W-1:0]  != '0));
  assign pageBad  = (inUse[0] && pageCross(insSrcA[PAGE_W-1:0], insBytes)) ||
                    (inUse[1] && pageCross(insSrcB[PAGE_W-1:0], keyBytes)) ||
                    (inUse[2] && pageCross(insDst[PAGE_W-1:0],  insBytes));
  assign excCode  = sizeBad ? EXC_SIZE : alignBad ? EXC_ALIGN :
                    pageBad ? EXC_PAGE : EXC_NONE;

  assign locUse = inUse & ~{1'b0, inOp == OP_SEARCH, 1'b0};
  assign nearIn = (locUse[0] && locUse[1] && (insSrcA[PAGE_W-1:0] != insSrcB[PAGE_W-1:0])) ||
                  (locUse[0] && locUse[2] && (insSrcA[PAGE_W-1:0] != insDst[PAGE_W-1:0]))  ||
                  (locUse[1] && locUse[2] && (insSrcB[PAGE_W-1:0] != insDst[PAGE_W-1:0]));

  // current operation
  logic [ADDR_W-1:0]  opOff;
  logic [CNT_W-1:0]   remaining;
  logic [2:0]         missing, selHot;
  logic [WPB-1:0]     wordMask;
  logic [PART_W-1:0]  part;

  assign opOff     = ADDR_W'({nextOp, {BLK_W{1'b0}}});
  assign cmdAddrA  = baseA + opOff;
  assign cmdAddrB  = (curOp == OP_SEARCH) ? baseB : baseB + opOff;
  assign cmdAddrD  = baseD + opOff;
  assign remaining = {1'b0, words} - CNT_W'({nextOp, {WPB_W{1'b0}}});
  assign lastOp    = remaining <= CNT_W'(WPB);
  assign cmdWords  = lastOp ? remaining[WPB_W:0] : 4'(WPB);
  assign missing   = opUse(curOp) & ~present;
  assign allPresent = (missing == 3'b000);
  assign part      = cmdAddrA[BLK_W +: PART_W];
  assign needKey   = (curOp == OP_SEARCH) && !keyTab[part];
  assign retryLast = retryCnt == RETRY_W'(RETRY_LIMIT - 1);

  always_comb begin
    if (missing[0])      fetchSel = 2'd0;
    else if (missing[1]) fetchSel = 2'd1;
    else                 fetchSel = 2'd2;
    selHot = 3'b001 << fetchSel;
    case (fetchSel)
      2'd0:    fetchAddr = cmdAddrA;
      2'd1:    fetchAddr = cmdAddrB;
      default: fetchAddr = cmdAddrD;
    endcase
    for (int j = 0; j < WPB; j++) wordMask[j] = 4'(j) < cmdWords;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOp <= OP_COPY; baseA <= '0; baseB <= '0; baseD <= '0; words <= '0;
      nextOp <= '0; result <= '0; status <= ST_OK; excReg <= EXC_NONE;
      near <= 1'b0; retryCnt <= '0; keyTab <= '0; present <= '0;
    end else begin
      if (stb.latch) begin
        curOp <= inOp; baseA <= insSrcA; baseB <= insSrcB; baseD <= insDst;
        words <= insWords; nextOp <= '0; result <= '0; status <= ST_OK;
        excReg <= excCode; near <= nearIn; retryCnt <= '0; keyTab <= '0;
        present <= '0;
      end
      if (stb.setStatus)  status <= stb.status;
      if (stb.setPresent) present <= present | selHot;
      if (stb.bumpRetry) begin
        present  <= '0;
        retryCnt <= retryCnt + 1'b1;
      end
      if (stb.setKey) keyTab[part] <= 1'b1;
      if (stb.accum && isReduce(curOp))
        result[{nextOp[RES_IDX_W-1:0], {WPB_W{1'b0}}} +: WPB] <= cmdMatch & wordMask;
      if (stb.advance) begin
        nextOp  <= nextOp + 1'b1;
        present <= '0;
      end
    end
  end

  assign cmdOp      = curOp;
  assign cmdNear    = near;
  assign doneStatus = status;
  assign doneExc    = excReg;
  assign doneResult = result;

endmodule

// File: rtl/cc_seq_ctrl.sv
module cc_seq_ctrl
  import cc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       insValid,
  input  logic       fetchAck,
  input  logic       lockLost,
  input  logic       cmdAck,
  input  logic [1:0] excCode,
  input  logic       allPresent,
  input  logic       lastOp,
  input  logic       needKey,
  input  logic       retryLast,
  output seqStrobe_t stb,
  output logic       insReady,
  output logic       fetchValid,
  output logic       cmdValid,
  output logic       cmdKeyCopy,
  output logic       doneValid
);
  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (insValid) begin
        stb.latch = 1'b1;
        if (excCode != EXC_NONE) begin
          stb.setStatus = 1'b1;
          stb.status    = ST_EXC;
          nextState     = S_DONE;
        end else begin
          nextState = S_FETCH;
        end
      end
      S_FETCH: begin
        if (lockLost) begin
          stb.bumpRetry = 1'b1;
          if (retryLast) begin
            stb.setStatus = 1'b1;
            stb.status    = ST_FALLBACK;
            nextState     = S_DONE;
          end
        end else if (allPresent) begin
          nextState = needKey ? S_KEY : S_ISSUE;
        end else if (fetchAck) begin
          stb.setPresent = 1'b1;
        end
      end
      S_KEY: if (cmdAck) begin
        stb.setKey = 1'b1;
        nextState  = S_ISSUE;
      end
      S_ISSUE: if (cmdAck) begin
        stb.accum = 1'b1;
        if (lastOp) nextState = S_DONE;
        else begin
          stb.advance = 1'b1;
          nextState   = S_FETCH;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign insReady   = (state == S_IDLE);
  assign fetchValid = (state == S_FETCH) && !allPresent;
  assign cmdValid   = (state == S_KEY) || (state == S_ISSUE);
  assign cmdKeyCopy = (state == S_KEY);
  assign doneValid  = (state == S_DONE);

endmodule

// File: rtl/cc_vec_sequencer.sv
module cc_vec_sequencer
  import cc_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORDS_W     = 8,
  parameter int NUM_PART    = 4,
  parameter int RETRY_LIMIT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               insValid,
  output logic               insReady,
  input  logic [2:0]         insOp,
  input  logic [ADDR_W-1:0]  insSrcA,
  input  logic [ADDR_W-1:0]  insSrcB,
  input  logic [ADDR_W-1:0]  insDst,
  input  logic [WORDS_W-1:0] insWords,
  output logic               fetchValid,
  output logic [1:0]         fetchSel,
  output logic [ADDR_W-1:0]  fetchAddr,
  input  logic               fetchAck,
  input  logic               lockLost,
  output logic               cmdValid,
  output logic               cmdKeyCopy,
  output logic [2:0]         cmdOp,
  output logic               cmdNear,
  output logic [3:0]         cmdWords,
  output logic [ADDR_W-1:0]  cmdAddrA,
  output logic [ADDR_W-1:0]  cmdAddrB,
  output logic [ADDR_W-1:0]  cmdAddrD,
  input  logic               cmdAck,
  input  logic [7:0]         cmdMatch,
  output logic               doneValid,
  output logic [1:0]         doneStatus,
  output logic [1:0]         doneExc,
  output logic [63:0]        doneResult
);
  seqStrobe_t stb;
  logic [1:0] excCode;
  logic       allPresent, lastOp, needKey, retryLast;

  cc_seq_ctrl u_ctrl (
    .clk, .rstN, .insValid, .fetchAck, .lockLost, .cmdAck, .excCode,
    .allPresent, .lastOp, .needKey, .retryLast, .stb, .insReady,
    .fetchValid, .cmdValid, .cmdKeyCopy, .doneValid
  );

  cc_seq_datapath #(
    .ADDR_W(ADDR_W), .WORDS_W(WORDS_W), .NUM_PART(NUM_PART),
    .RETRY_LIMIT(RETRY_LIMIT), .RES_W(64)
  ) u_dp (
    .clk, .rstN, .stb, .insOp, .insSrcA, .insSrcB, .insDst, .insWords,
    .cmdMatch, .excCode, .allPresent, .lastOp, .needKey, .retryLast,
    .fetchSel, .fetchAddr, .cmdOp, .cmdNear, .cmdWords, .cmdAddrA,
    .cmdAddrB, .cmdAddrD, .doneStatus, .doneExc, .doneResult
  );

endmodule

// File: rtl/cc_vec_sequencer_chk.sv
module cc_vec_sequencer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              insReady,
  input logic              fetchValid,
  input logic              lockLost,
  input logic              cmdValid,
  input logic              cmdAck,
  input logic              cmdKeyCopy,
  input logic [ADDR_W-1:0] cmdAddrA,
  input logic              doneValid,
  input logic [1:0]        doneStatus
);
  a_r1_busy_no_ready: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid || fetchValid) |-> !insReady);

  a_r3_fetch_or_cmd: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchValid && cmdValid));

  a_r2_cmd_held: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdAck) |=> (cmdValid && $stable(cmdAddrA) && $stable(cmdKeyCopy)));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r9_fallback_cause: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == 2'd2) |-> $past(lockLost));

  a_r4_exc_immediate: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == 2'd1) |-> $past(insReady));
endmodule

bind cc_vec_sequencer cc_vec_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_cc_vec_sequencer.sv
module tb_cc_vec_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        insValid = 1'b0;
  logic        insReady;
  logic [2:0]  insOp = '0;
  logic [31:0] insSrcA = '0, insSrcB = '0, insDst = '0;
  logic [7:0]  insWords = '0;
  logic        fetchValid;
  logic [1:0]  fetchSel;
  logic [31:0] fetchAddr;
  logic        fetchAck = 1'b0, lockLost = 1'b0;
  logic        cmdValid, cmdKeyCopy, cmdNear;
  logic [2:0]  cmdOp;
  logic [3:0]  cmdWords;
  logic [31:0] cmdAddrA, cmdAddrB, cmdAddrD;
  logic        cmdAck = 1'b0;
  logic [7:0]  cmdMatch = '0;
  logic        doneValid;
  logic [1:0]  doneStatus, doneExc;
  logic [63:0] doneResult;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_vec_sequencer dut (.*);

  typedef struct {
    logic [1:0]  st;
    logic [1:0]  exc;
    logic [63:0] res;
    int          ops, keys, fetches, wsum;
    logic        near;
    string       req;
  } exp_t;

  exp_t q[$];
  int errors = 0, checks = 0;
  int lockBudget = 0, fetchLat = 0, fetchWait = 0;
  int opSeen = 0, keySeen = 0, fetchSeen = 0, wordSeen = 0, addrErr = 0;
  logic nearSeen = 1'b0;
  logic [31:0] curA, curB, curD;
  logic [2:0]  curOp;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] matchOf(logic [31:0] a);
    return (a[13:6] * 8'd37) ^ 8'h5C;
  endfunction

  function automatic logic [2:0] useOf(logic [2:0] op);
    case (op)
      3'd0, 3'd5:       return 3'b101;
      3'd1:             return 3'b100;
      3'd2, 3'd3, 3'd4: return 3'b111;
      default:          return 3'b011;
    endcase
  endfunction

  function automatic logic crosses(logic [31:0] base, int bytes);
    return ((base % 4096) + bytes - 1) >= 4096;
  endfunction

  // array and residency model, plus completion monitor
  always @(negedge clk) begin
    lockLost = 1'b0; fetchAck = 1'b0; cmdAck = 1'b0;
    if (rstN) begin
      if (fetchValid) begin
        if (lockBudget > 0) begin
          lockLost = 1'b1; lockBudget--;
        end else if (fetchWait >= fetchLat) begin
          fetchAck = 1'b1; fetchWait = 0; fetchSeen++;
        end else fetchWait++;
      end
      if (cmdValid) begin
        cmdAck   = 1'b1;
        cmdMatch = matchOf(cmdAddrA);
        if (cmdKeyCopy) begin
          keySeen++;
          if (cmdAddrB !== curB) addrErr++;
        end else begin
          if (cmdAddrA !== curA + 32'(64*opSeen)) addrErr++;
          if (cmdAddrD !== curD + 32'(64*opSeen)) addrErr++;
          if (cmdAddrB !== ((curOp == 3'd7) ? curB : curB + 32'(64*opSeen))) addrErr++;
          nearSeen |= cmdNear;
          wordSeen += int'(cmdWords);
          opSeen++;
        end
      end
      if (doneValid) begin
        exp_t e;
        if (q.size() == 0) chk("R11 unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk({e.req, " status"}, doneStatus, e.st);
          chk({e.req, " exc"}, doneExc, e.exc);
          chk({e.req, " R7 result"}, doneResult, e.res);
          chk({e.req, " R2 ops"}, opSeen, e.ops);
          chk({e.req, " R2 addr"}, addrErr, 0);
          chk({e.req, " R2 words"}, wordSeen, e.wsum);
          chk({e.req, " R8 keys"}, keySeen, e.keys);
          chk({e.req, " R3 fetches"}, fetchSeen, e.fetches);
          chk({e.req, " R10 near"}, nearSeen, e.near);
        end
        opSeen = 0; keySeen = 0; fetchSeen = 0; wordSeen = 0; addrErr = 0;
        nearSeen = 1'b0; fetchWait = 0;
      end
    end
  end

  // driver: builds the expected record from the requirements, then offers the instruction
  task automatic send(string req, logic [2:0] op, logic [31:0] a, logic [31:0] b,
                      logic [31:0] d, int w, int locks, int lat);
    exp_t e;
    logic [2:0] u = useOf(op);
    logic [2:0] lu;
    logic red = (op == 3'd6) || (op == 3'd7);
    logic [3:0] keyed = '0;
    int nOps;
    e.req = req; e.res = '0; e.keys = 0; e.exc = 2'd0; e.st = 2'd0;
    if (w == 0 || (red && w > 64)) e.exc = 2'd2;
    else if ((u[0] && a[5:0] != 0) || (u[1] && b[5:0] != 0) || (u[2] && d[5:0] != 0))
      e.exc = 2'd3;
    else if ((u[0] && crosses(a, 8*w)) || (u[1] && crosses(b, (op == 3'd7) ? 64 : 8*w)) ||
             (u[2] && crosses(d, 8*w)))
      e.exc = 2'd1;
    nOps = (w + 7) / 8;
    lu = u & ~{1'b0, op == 3'd7, 1'b0};
    e.near = (lu[0] && lu[1] && a[11:0] != b[11:0]) || (lu[0] && lu[2] && a[11:0] != d[11:0]) ||
             (lu[1] && lu[2] && b[11:0] != d[11:0]);
    if (e.exc != 0 || locks >= 2) begin
      e.st = (e.exc != 0) ? 2'd1 : 2'd2;
      e.ops = 0; e.fetches = 0; e.wsum = 0; e.near = 1'b0;
    end else begin
      e.ops = nOps; e.wsum = w;
      e.fetches = nOps * $countones(u);
      for (int k = 0; k < nOps; k++) begin
        logic [31:0] ak = a + 32'(64*k);
        int wc = (w - 8*k > 8) ? 8 : w - 8*k;
        if (red) e.res[8*k +: 8] = matchOf(ak) & 8'((1 << wc) - 1);
        if (op == 3'd7 && !keyed[ak[7:6]]) begin
          keyed[ak[7:6]] = 1'b1; e.keys++;
        end
      end
    end
    q.push_back(e);
    while (!insReady) @(negedge clk);
    curA = a; curB = b; curD = d; curOp = op;
    lockBudget = locks; fetchLat = lat;
    insOp = op; insSrcA = a; insSrcB = b; insDst = d; insWords = 8'(w);
    insValid = 1'b1;
    @(negedge clk);
    insValid = 1'b0;
    chk({req, " R1 ready low while busy"}, insReady, 0);
    while (q.size() != 0) @(negedge clk);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 insReady", insReady, 1);
    chk("R12 fetchValid", fetchValid, 0);
    chk("R12 cmdValid", cmdValid, 0);
    chk("R12 doneValid", doneValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 ready after reset", insReady, 1);

    send("R2 and 24w",        3'd2, 32'h1000_0000, 32'h1100_0000, 32'h1200_0000, 24, 0, 0);
    send("R7 cmp 20w",        3'd6, 32'h1000_0100, 32'h2000_0100, 32'h0,        20, 0, 2);
    send("R8 search 64w",     3'd7, 32'h3000_0000, 32'h4000_0040, 32'h0,        64, 0, 1);
    send("R10 xor near",      3'd4, 32'h5000_0000, 32'h5100_0000, 32'h5000_0080, 16, 0, 0);
    send("R3 zero 8w",        3'd1, 32'h0,        32'h0,        32'hA000_0000,  8, 0, 3);
    send("R2 copy 5w",        3'd0, 32'h6000_0040, 32'h0,       32'h6100_0040,  5, 0, 0);
    send("R4 page cross",     3'd0, 32'h1000_0FC0, 32'h0,       32'h2000_0FC0, 16, 0, 0);
    send("R5 cmp 65w",        3'd6, 32'h0,        32'h0,        32'h0,         65, 0, 0);
    send("R5 zero 0w",        3'd1, 32'h0,        32'h0,        32'h0,          0, 0, 0);
    send("R6 not misaligned", 3'd5, 32'h6000_0004, 32'h0,       32'h7000_0000,  8, 0, 0);
    send("R5 over R6 prio",   3'd6, 32'h6000_0004, 32'h0,       32'h0,         70, 0, 0);
    send("R9 one lock loss",  3'd0, 32'h8000_0000, 32'h0,       32'h9000_0000,  8, 1, 0);
    send("R9 two lock loss",  3'd0, 32'h8000_0000, 32'h0,       32'h9000_0000, 16, 2, 0);
    send("R11 or after fb",   3'd3, 32'hB000_0000, 32'hB100_0000, 32'hB200_0000, 9, 0, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule